// File: doc/BRIEF.md
# DDR2 Write-Interrupt Timing Checker

This block is a passive monitor on a DDR2-style command bus. Each cycle it reads a decoded command, a bank number and the A10 address bit. It judges whether a WRITE burst that is cut short by a later WRITE follows the interrupt rules, and whether each PRECHARGE waits for write recovery. The block drives nothing on the bus. It raises a one-cycle error pulse with a 3-bit code in the same cycle as the offending command, and it keeps one sticky flag per error kind.

Three mode inputs describe the memory setup: burst length (BL8 or BL4), additive latency and CAS latency. These inputs must stay constant while reset is released. Write latency is captured as AL + CL − 1 while reset is asserted. A small state machine follows the distance to the most recent WRITE in the states ST_IDLE, ST_D1, ST_D2 and ST_D3. Its transitions are:

- Any WRITE moves it to ST_D1.
- In ST_D1, a non-WRITE moves it to ST_D2 under BL8 and to ST_IDLE under BL4.
- In ST_D2, a non-WRITE moves it to ST_D3.
- In ST_D3, a non-WRITE moves it to ST_IDLE.

One down-counter per bank holds the number of cycles until a PRECHARGE to that bank becomes legal.

Top module: `wr_intr_monitor`

## Requirements
- R1: During and just after reset, err_pulse is 0, err_code is 0 and every err_sticky bit is 0.
- R2: Command encoding on cmd is 0 = NOP, 1 = DESELECT, 2 = WRITE, 3 = PRECHARGE, and 4 to 7 = any other command. err_pulse is high exactly when err_code is non-zero, and a NOP or DESELECT cycle never raises err_pulse. When several errors occur in one cycle, err_code reports the lowest code number.
- R3: With bl8 = 0 (BL4), a WRITE one cycle after a WRITE gives code 1. A WRITE two or more cycles after a WRITE is legal.
- R4: With bl8 = 1 (BL8), a WRITE one or three cycles after the previous WRITE gives code 2. A distance of four or more is legal.
- R5: With BL8, a WRITE exactly two cycles after a WRITE that carried A10 = 1 gives code 3. The A10 value and the bank of the interrupting WRITE never cause an error.
- R6: With BL8, when the command between two WRITEs spaced two cycles apart is neither NOP nor DESELECT, the second WRITE gives code 4.
- R7: A PRECHARGE with A10 = 0 to a bank gives code 5 when it arrives fewer than WL + BL/2 + TWR cycles after the last WRITE to that bank. Here WL = AL + CL − 1, captured during reset, and TWR is a parameter.
- R8: The recovery window of an interrupted WRITE is measured from the end of its full programmed burst. A PRECHARGE to its bank at the truncated-burst deadline is still flagged with code 5.
- R9: A PRECHARGE with A10 = 1 addresses all banks and gives code 5 if any bank is still within its recovery window.
- R10: err_sticky bit i is set in the cycle after any error with code i+1, including errors that lose the priority in R2. It stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also captures write latency |
| cmd | input | 3 | Decoded command (encoding in R2) |
| bank | input | 3 | Bank address of the command |
| a10 | input | 1 | A10 bit (auto precharge for WRITE, all-banks for PRECHARGE) |
| bl8 | input | 1 | 1 = burst length 8, 0 = burst length 4 |
| al | input | 3 | Additive latency in cycles |
| cl | input | 3 | CAS latency in cycles (at least 1) |
| err_pulse | output | 1 | High in the cycle of a violation |
| err_code | output | 3 | Code of the reported violation, 0 when none |
| err_sticky | output | 5 | Per-code sticky error flags |

## Verification
The bench keeps the default parameters: 8 banks and TWR = 3. It runs three reset phases with different modes:

- BL8 with AL 0 and CL 4, which gives a recovery of 10 cycles.
- BL4 with AL 1 and CL 3, which gives 8 cycles.
- BL8 with AL 2 and CL 5, which gives 13 cycles.

These phases exercise both burst-length branches of the state machine, and each one sets a different counter load. In the short windows, dense random WRITE and PRECHARGE traffic can land on every interrupt distance and on both sides of each recovery deadline. The all-banks precharge is checked against pending counters in several banks at once.

// File: rtl/wim_pkg.sv
`timescale 1ns/1ps
package wim_pkg;

    localparam logic [2:0] CMD_NOP = 3'd0;
    localparam logic [2:0] CMD_DES = 3'd1;
    localparam logic [2:0] CMD_WR  = 3'd2;
    localparam logic [2:0] CMD_PRE = 3'd3;

    localparam int NUM_ERR = 5;

    localparam logic [2:0] ERR_NONE  = 3'd0;
    localparam logic [2:0] ERR_BL4   = 3'd1;
    localparam logic [2:0] ERR_SPACE = 3'd2;
    localparam logic [2:0] ERR_AP    = 3'd3;
    localparam logic [2:0] ERR_GAP   = 3'd4;
    localparam logic [2:0] ERR_EARLY = 3'd5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_D1   = 2'd1,
        ST_D2   = 2'd2,
        ST_D3   = 2'd3
    } wim_state_t;

endpackage

// File: rtl/wim_intr_fsm.sv
`timescale 1ns/1ps
module wim_intr_fsm
    import wim_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic is_wr,
    input  logic is_quiet,
    input  logic a10,
    input  logic bl8,
    output logic f_bl4,
    output logic f_space,
    output logic f_ap,
    output logic f_gap
);

    wim_state_t state;
    wim_state_t nxt;
    logic       prev_ap;
    logic       gap_dirty;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // context of the most recent WRITE and of the slot after it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_ap   <= 1'b0;
            gap_dirty <= 1'b0;
        end else begin
            if (is_wr) begin
                prev_ap <= a10;
            end
            if (state == ST_D1 && !is_wr) begin
                gap_dirty <= !is_quiet;
            end
        end
    end

    // next state and violation flags
    always_comb begin
        nxt     = state;
        f_bl4   = 1'b0;
        f_space = 1'b0;
        f_ap    = 1'b0;
        f_gap   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (is_wr) begin
                    nxt = ST_D1;
                end
            end
            ST_D1: begin
                if (is_wr) begin
                    nxt = ST_D1;
                    if (!bl8) begin
                        f_bl4 = 1'b1;
                    end else begin
                        f_space = 1'b1;
                    end
                end else begin
                    nxt = bl8 ? ST_D2 : ST_IDLE;
                end
            end
            ST_D2: begin
                if (is_wr) begin
                    nxt   = ST_D1;
                    f_ap  = prev_ap;
                    f_gap = gap_dirty;
                end else begin
                    nxt = ST_D3;
                end
            end
            ST_D3: begin
                if (is_wr) begin
                    nxt     = ST_D1;
                    f_space = 1'b1;
                end else begin
                    nxt = ST_IDLE;
                end
            end
            default: begin
                nxt = ST_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/wim_bank_timer.sv
`timescale 1ns/1ps
module wim_bank_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] dec;

    assign dec = (cnt == '0) ? '0 : cnt - 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= (load_val > dec) ? load_val : dec;
        end else begin
            cnt <= dec;
        end
    end

    assign busy = (cnt != '0);

endmodule

// File: rtl/wim_err_collect.sv
`timescale 1ns/1ps
module wim_err_collect
    import wim_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_ERR-1:0] hit,
    output logic               pulse,
    output logic [2:0]         code,
    output logic [NUM_ERR-1:0] sticky
);

    // lowest code wins: scan from the top so the lowest index is assigned last
    always_comb begin
        code = ERR_NONE;
        for (int i = NUM_ERR - 1; i >= 0; i--) begin
            if (hit[i]) begin
                code = 3'(i + 1);
            end
        end
    end

    assign pulse = |hit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky <= '0;
        end else begin
            sticky <= sticky | hit;
        end
    end

endmodule

// File: rtl/wr_intr_monitor.sv
`timescale 1ns/1ps
module wr_intr_monitor
    import wim_pkg::*;
#(
    parameter int NBANK  = 8,
    parameter int BANK_W = $clog2(NBANK),
    parameter int AL_W   = 3,
    parameter int CL_W   = 3,
    parameter int TWR    = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         cmd,
    input  logic [BANK_W-1:0]  bank,
    input  logic               a10,
    input  logic               bl8,
    input  logic [AL_W-1:0]    al,
    input  logic [CL_W-1:0]    cl,
    output logic               err_pulse,
    output logic [2:0]         err_code,
    output logic [NUM_ERR-1:0] err_sticky
);

    localparam int MAX_REC = (1 << AL_W) + (1 << CL_W) + 4 + TWR;
    localparam int CNT_W   = $clog2(MAX_REC) + 1;

    logic             is_wr;
    logic             is_pre;
    logic             is_quiet;
    logic [CNT_W-1:0] wl_q;
    logic [CNT_W-1:0] half_burst;
    logic [CNT_W-1:0] rec_m1;
    logic [NBANK-1:0] busy;
    logic             f_bl4;
    logic             f_space;
    logic             f_ap;
    logic             f_gap;
    logic             f_early;
    logic [NUM_ERR-1:0] hit;

    assign is_wr    = (cmd == CMD_WR);
    assign is_pre   = (cmd == CMD_PRE);
    assign is_quiet = (cmd == CMD_NOP) || (cmd == CMD_DES);

    // write latency captured while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wl_q <= CNT_W'(al) + CNT_W'(cl) - CNT_W'(1);
        end
    end

    // recovery is always timed from the full programmed burst
    assign half_burst = bl8 ? CNT_W'(4) : CNT_W'(2);
    assign rec_m1     = wl_q + half_burst + CNT_W'(TWR) - CNT_W'(1);

    wim_intr_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .is_wr    (is_wr),
        .is_quiet (is_quiet),
        .a10      (a10),
        .bl8      (bl8),
        .f_bl4    (f_bl4),
        .f_space  (f_space),
        .f_ap     (f_ap),
        .f_gap    (f_gap)
    );

    for (genvar gi = 0; gi < NBANK; gi++) begin : g_bank
        wim_bank_timer #(
            .CNT_W (CNT_W)
        ) u_timer (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (is_wr && (bank == BANK_W'(gi))),
            .load_val (rec_m1),
            .busy     (busy[gi])
        );
    end

    assign f_early = is_pre && (a10 ? (|busy) : busy[bank]);

    assign hit = {f_early, f_gap, f_ap, f_space, f_bl4};

    wim_err_collect u_err (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (hit),
        .pulse  (err_pulse),
        .code   (err_code),
        .sticky (err_sticky)
    );

endmodule

// File: rtl/wim_checker.sv
`timescale 1ns/1ps
module wim_checker
    import wim_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [2:0]         cmd,
    input logic               bl8,
    input logic               err_pulse,
    input logic [2:0]         err_code,
    input logic [NUM_ERR-1:0] err_sticky
);

    AST_PULSE_MATCHES_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse == (err_code != ERR_NONE)); // R2

    AST_QUIET_NO_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_NOP || cmd == CMD_DES) |-> !err_pulse); // R2

    AST_BL4_ONLY_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bl8 && cmd == CMD_WR) |-> (err_code == ERR_NONE || err_code == ERR_BL4)); // R3

    AST_BL8_NO_BL4_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        bl8 |-> (err_code != ERR_BL4)); // R4

    AST_WRITE_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_WR) |-> (err_code != ERR_EARLY)); // R7

    AST_PRE_ONLY_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRE && err_pulse) |-> (err_code == ERR_EARLY)); // R9

    AST_STICKY_NEVER_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((err_sticky & $past(err_sticky)) == $past(err_sticky))); // R10

    AST_PULSE_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> ((err_sticky & (NUM_ERR'(1) << ($past(err_code) - 3'd1))) != '0)); // R10

endmodule

bind wr_intr_monitor wim_checker i_wim_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd        (cmd),
    .bl8        (bl8),
    .err_pulse  (err_pulse),
    .err_code   (err_code),
    .err_sticky (err_sticky)
);

// File: tb/test_wr_intr_monitor.sv
`timescale 1ns/1ps
module test_wr_intr_monitor;

    localparam int TWR = 3;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] cmd;
    logic [2:0] bank;
    logic       a10;
    logic       bl8;
    logic [2:0] al;
    logic [2:0] cl;
    logic       err_pulse;
    logic [2:0] err_code;
    logic [4:0] err_sticky;

    int checks = 0;
    int bad    = 0;
    bit done   = 0;

    // reference model state
    int   cyc;
    int   last_wr;
    bit   last_ap;
    bit   gap_bad;
    int   dl [8];
    int   m_wl;
    bit   m_bl8;
    logic [4:0] exp_sticky;

    always #2.5 clk = ~clk;

    wr_intr_monitor i_wr_intr_monitor (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (cmd),
        .bank       (bank),
        .a10        (a10),
        .bl8        (bl8),
        .al         (al),
        .cl         (cl),
        .err_pulse  (err_pulse),
        .err_code   (err_code),
        .err_sticky (err_sticky)
    );

    function automatic logic [4:0] model_hits(input logic [2:0] c, input logic [2:0] b, input logic a);
        logic [4:0] h = '0;
        int half = m_bl8 ? 4 : 2;
        int d = cyc - last_wr;
        if (c == 3'd2 && d < half) begin
            if (!m_bl8) h[0] = 1'b1;
            else if (d != 2) h[1] = 1'b1;
            else begin
                if (last_ap) h[2] = 1'b1;
                if (gap_bad) h[3] = 1'b1;
            end
        end
        if (c == 3'd3) begin
            if (a) begin
                for (int i = 0; i < 8; i++) if (cyc < dl[i]) h[4] = 1'b1;
            end else if (cyc < dl[b]) h[4] = 1'b1;
        end
        return h;
    endfunction

    function automatic logic [2:0] model_code(input logic [4:0] h);
        for (int i = 0; i < 5; i++) if (h[i]) return 3'(i + 1);
        return 3'd0;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // inputs set at a falling edge; outputs checked just before the rising edge
    task automatic step(input logic [2:0] c, input logic [2:0] b, input logic a, input string req);
        logic [4:0] h;
        logic [2:0] ec;
        cmd = c; bank = b; a10 = a;
        #2;
        h  = model_hits(c, b, a);
        ec = model_code(h);
        check(err_code == ec && err_pulse == (ec != 0), req, int'(err_code), int'(ec));
        check(err_sticky == exp_sticky, "R10", int'(err_sticky), int'(exp_sticky));
        exp_sticky = exp_sticky | h;
        if (c != 3'd2 && cyc == last_wr + 1) gap_bad = (c > 3'd1);
        if (c == 3'd2) begin
            int nd = cyc + m_wl + (m_bl8 ? 4 : 2) + TWR;
            if (nd > dl[b]) dl[b] = nd;
            last_wr = cyc;
            last_ap = a;
        end
        cyc++;
        @(negedge clk);
    endtask

    task automatic nops(input int n);
        for (int i = 0; i < n; i++) step(3'd0, 3'd0, 1'b0, "R2");
    endtask

    task automatic do_reset(input bit b8, input logic [2:0] al_v, input logic [2:0] cl_v);
        @(negedge clk);
        rst_n = 1'b0; cmd = 3'd0; bank = '0; a10 = 1'b0;
        bl8 = b8; al = al_v; cl = cl_v;
        repeat (3) @(negedge clk);
        #2;
        check(err_pulse == 1'b0 && err_code == 3'd0, "R1", int'(err_code), 0);
        check(err_sticky == 5'd0, "R1", int'(err_sticky), 0);
        @(negedge clk);
        rst_n = 1'b1;
        cyc = 0; last_wr = -1000; last_ap = 0; gap_bad = 0;
        for (int i = 0; i < 8; i++) dl[i] = -1000;
        m_wl = int'(al_v) + int'(cl_v) - 1;
        m_bl8 = b8;
        exp_sticky = '0;
    endtask

    task automatic random_run(input int n);
        for (int i = 0; i < n; i++) begin
            int r = $urandom % 100;
            logic [2:0] c;
            if (r < 45) c = 3'd0;
            else if (r < 55) c = 3'd1;
            else if (r < 77) c = 3'd2;
            else if (r < 94) c = 3'd3;
            else c = 3'(4 + $urandom % 4);
            step(c, 3'($urandom % 8), ($urandom % 100) < 25, "R2");
        end
    endtask

    initial begin
        void'($urandom(32'd2718));
        rst_n = 1'b0; cmd = '0; bank = '0; a10 = 0; bl8 = 1; al = 0; cl = 4;

        // phase 1: BL8, AL 0, CL 4 -> recovery 10 cycles
        do_reset(1'b1, 3'd0, 3'd4);
        nops(2);
        step(3'd2, 3'd0, 1'b0, "R5");
        step(3'd0, 3'd0, 1'b0, "R5");
        step(3'd2, 3'd1, 1'b1, "R5");       // legal interrupt, own A10 high
        step(3'd0, 3'd0, 1'b0, "R5");
        step(3'd2, 3'd2, 1'b0, "R5");       // interrupts WRITE with A10 high -> 3
        nops(6);
        step(3'd2, 3'd3, 1'b0, "R4");
        step(3'd2, 3'd3, 1'b0, "R4");       // distance 1 -> 2
        nops(6);
        step(3'd2, 3'd4, 1'b0, "R4");
        nops(2);
        step(3'd2, 3'd4, 1'b0, "R4");       // distance 3 -> 2
        nops(3);
        step(3'd2, 3'd4, 1'b0, "R4");       // distance 4 -> legal
        nops(5);
        step(3'd2, 3'd5, 1'b0, "R6");
        step(3'd3, 3'd6, 1'b0, "R6");       // idle bank, legal precharge in gap
        step(3'd2, 3'd5, 1'b0, "R6");       // gap not quiet -> 4
        nops(5);
        step(3'd2, 3'd0, 1'b1, "R6");
        step(3'd5, 3'd0, 1'b0, "R6");
        step(3'd2, 3'd1, 1'b0, "R6");       // codes 3 and 4 together, pulse shows 3
        nops(14);
        step(3'd2, 3'd3, 1'b0, "R7");
        nops(8);
        step(3'd3, 3'd3, 1'b0, "R7");       // 9 cycles after -> early
        step(3'd3, 3'd3, 1'b0, "R7");       // 10 cycles after -> legal
        nops(14);
        step(3'd2, 3'd6, 1'b0, "R8");
        step(3'd0, 3'd0, 1'b0, "R8");
        step(3'd2, 3'd7, 1'b0, "R8");
        nops(5);
        step(3'd3, 3'd6, 1'b0, "R8");       // truncated deadline: still early
        step(3'd0, 3'd0, 1'b0, "R8");
        step(3'd3, 3'd6, 1'b0, "R8");       // full-burst deadline reached
        nops(14);
        step(3'd2, 3'd2, 1'b0, "R9");
        nops(3);
        step(3'd3, 3'd5, 1'b1, "R9");       // all banks, bank 2 pending -> 5
        step(3'd3, 3'd5, 1'b0, "R9");       // bank 5 alone is free
        nops(14);
        step(3'd3, 3'd0, 1'b1, "R9");       // all banks idle
        random_run(3000);

        // phase 2: BL4, AL 1, CL 3 -> recovery 8 cycles
        do_reset(1'b0, 3'd1, 3'd3);
        step(3'd2, 3'd1, 1'b0, "R3");
        step(3'd2, 3'd1, 1'b0, "R3");       // BL4 interrupt -> 1
        step(3'd0, 3'd0, 1'b0, "R3");
        step(3'd2, 3'd2, 1'b1, "R3");
        step(3'd0, 3'd0, 1'b0, "R3");
        step(3'd2, 3'd3, 1'b0, "R3");       // seamless BL4, legal
        nops(6);
        step(3'd3, 3'd3, 1'b0, "R7");       // 7 cycles -> early
        step(3'd3, 3'd3, 1'b0, "R7");       // 8 cycles -> legal
        random_run(3000);

        // phase 3: BL8, AL 2, CL 5 -> recovery 13 cycles
        do_reset(1'b1, 3'd2, 3'd5);
        step(3'd2, 3'd4, 1'b0, "R7");
        nops(11);
        step(3'd3, 3'd4, 1'b0, "R7");       // 12 cycles -> early
        step(3'd3, 3'd4, 1'b0, "R7");       // 13 cycles -> legal
        random_run(3000);

        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule